// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block is a register-mapped controller for five 8-bit general-purpose I/O ports. Each port has a data latch that drives its pins and a direction register that selects input or output for each pin. Ports 1 to 4 form a bank that one enable bit switches on or off. While the bank is off, its data latches are held at zero, writes to its data and direction registers are ignored, and its pins neither drive nor pull up.

Pull-ups are granted per nibble. A pull-up reaches a pin only when that pin is an input. A read-mode bit chooses what a read of port 0 returns: the pin levels of its input pins, or its output latch whatever the direction. Pad inputs pass through a two-flop synchronizer before they reach the read path. Reads are registered.

Software reaches the block through a simple synchronous bus with an address, write data, a write strobe and read data. The pin side has one bit per pin for the pad input, the output value, the output enable and the pull-up request.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous reset, every register holds 0. `pad_out`, `pad_oe`, `pad_pu` and `bus_rdata` are all 0.
- R2: The register map is as follows. Data of port k is at 0x3E0+2k and direction of port k is at 0x3E1+2k, for k = 0..4. The pull-up register is at 0x3DF and the read-mode register is at 0x3FF. A write takes effect at the edge where `bus_we` is 1. `bus_rdata` shows, one cycle later, the value addressed in the previous cycle. Unmapped addresses read 0.
- R3: A direction bit of 1 makes that pin an output. `pad_oe` follows the direction register and `pad_out` follows the data latch, bit for bit. Port k uses pin bits 8k+7..8k.
- R4: In the pull-up register, bit 2j enables the low nibble and bit 2j+1 the high nibble of port 1+(j), for j = 0..2. Bit 6 enables pins 0 and 1 of port 4 only. Port 0 and pins 2..7 of port 4 never get a pull-up.
- R5: `pad_pu` is 1 for a pin only when that pin's group bit is 1 and its direction bit is 0.
- R6: Bit 7 of the pull-up register enables the bank of ports 1..4. While it is 0:
  - the bank's data registers read 00h and are cleared;
  - writes to the bank's data and direction registers are ignored;
  - the bank's `pad_oe`, `pad_pu` and `pad_out` bits are 0.
- R7: With read-mode bit 0 at 0, a read of a data register returns the synchronized pad level for input pins and the latch for output pins. Ports 1..4 always read this way while the bank is enabled.
- R8: With read-mode bit 0 at 1, a read of port 0's data register returns its latch for every pin.
- R9: Bits 7..1 of the read-mode register ignore writes and read 0.
- R10: A pad level present at clock edge t appears in a data read addressed at edge t+2. It therefore shows on `bus_rdata` after edge t+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 40 | Pad input levels, port k at bits 8k+7..8k |
| pad_out | output | 40 | Output values |
| pad_oe | output | 40 | Output enables |
| pad_pu | output | 40 | Pull-up enables |

## Verification
Port 0 is read with a mixed direction pattern and a pad pattern that differs from the latch. This separates pin-level reads from latch reads under both settings of the read mode. The pull-up register is tried with all groups on while direction bits are mixed. This exposes a wrong nibble mapping, pull-ups that leak onto output pins, and any pull-up on the unused pins of port 4. The bank is written while disabled and then toggled off and on. This shows that writes are dropped, that the latches clear, and that the direction values survive. A pad step held under a constant read address measures the synchronizer depth exactly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PW         = 8;
    localparam int NPORT      = 5;
    localparam int NPIN       = NPORT * PW;
    localparam int AW         = 10;
    localparam int BANK_FIRST = 1;
    localparam int BANK_LAST  = 4;
    localparam int CTRL_PORT  = 0;
    localparam int NIB_GROUPS = 6;
    localparam int PAIR_PINS  = 2;
    localparam int BANK_BIT   = 7;
    localparam int PAIR_BIT   = 6;

    localparam logic [AW-1:0] ADDR_PUR       = 10'h3DF;
    localparam logic [AW-1:0] ADDR_RDMODE    = 10'h3FF;
    localparam logic [AW-1:0] ADDR_PORT_BASE = 10'h3E0;

    typedef struct packed {
        logic [PW-1:0] dir;
        logic [PW-1:0] data;
    } port_reg_t;

    function automatic logic [AW-1:0] data_addr(input int k);
        return ADDR_PORT_BASE + AW'(2 * k);
    endfunction

    function automatic logic [AW-1:0] dir_addr(input int k);
        return ADDR_PORT_BASE + AW'(2 * k + 1);
    endfunction

    function automatic logic [NPIN-1:0] pu_groups(input logic [PW-1:0] pur);
        logic [NPIN-1:0] m;
        m = '0;
        for (int j = 0; j < NIB_GROUPS; j++)
            m[BANK_FIRST*PW + 4*j +: 4] = {4{pur[j]}};
        m[BANK_LAST*PW +: PAIR_PINS] = {PAIR_PINS{pur[PAIR_BIT]}};
        return m;
    endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
    import gpio_pkg::*;
#(
    parameter logic [AW-1:0] BASE    = '0,
    parameter bit            IN_BANK = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [PW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bank_en,
    output port_reg_t     q
);
    logic held;
    assign held = IN_BANK && !bank_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (held) begin
            q.data <= '0;
        end else if (bus_we) begin
            if (bus_addr == BASE)
                q.data <= bus_wdata;
            if (bus_addr == BASE + AW'(1))
                q.dir <= bus_wdata;
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
(
    input  logic [AW-1:0]               addr,
    input  port_reg_t [NPORT-1:0]       regs,
    input  logic [PW-1:0]               pur,
    input  logic                        latch_mode,
    input  logic                        bank_en,
    input  logic [NPIN-1:0]             pad_sync,
    output logic [PW-1:0]               rd
);
    always_comb begin
        rd = '0;
        if (addr == ADDR_PUR)
            rd = pur;
        if (addr == ADDR_RDMODE)
            rd = {{(PW-1){1'b0}}, latch_mode};
        for (int k = 0; k < NPORT; k++) begin
            if (addr == data_addr(k)) begin
                if (k >= BANK_FIRST && !bank_en)
                    rd = '0;
                else if (k == CTRL_PORT && latch_mode)
                    rd = regs[k].data;
                else
                    rd = (regs[k].dir & regs[k].data)
                       | (~regs[k].dir & pad_sync[k*PW +: PW]);
            end
            if (addr == dir_addr(k))
                rd = regs[k].dir;
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [PW-1:0]   bus_wdata,
    input  logic            bus_we,
    output logic [PW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu
);
    logic [PW-1:0]         pur_q;
    logic                  pcr_q;
    logic                  bank_en;
    logic [NPIN-1:0]       pad_sync;
    logic [PW-1:0]         rd_next;
    port_reg_t [NPORT-1:0] regs;

    assign bank_en = pur_q[BANK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            pur_q <= '0;
            pcr_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_PUR)
                pur_q <= bus_wdata;
            if (bus_addr == ADDR_RDMODE)
                pcr_q <= bus_wdata[0];
        end
    end

    gpio_pad_sync #(.W(NPIN)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        localparam bit BANKED = (k >= BANK_FIRST);
        logic gate;

        gpio_port_reg #(.BASE(data_addr(k)), .IN_BANK(BANKED)) i_reg (
            .clk       (clk),
            .rst       (rst),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .bus_we    (bus_we),
            .bank_en   (bank_en),
            .q         (regs[k])
        );

        assign gate = !BANKED || bank_en;
        assign pad_out[k*PW +: PW] = gate ? regs[k].data : '0;
        assign pad_oe[k*PW +: PW]  = gate ? regs[k].dir  : '0;
    end

    assign pad_pu = pu_groups(pur_q) & ~pad_oe & {NPIN{bank_en}};

    gpio_read_mux i_rmux (
        .addr       (bus_addr),
        .regs       (regs),
        .pur        (pur_q),
        .latch_mode (pcr_q),
        .bank_en    (bank_en),
        .pad_sync   (pad_sync),
        .rd         (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic [PW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_pu,
    input logic [PW-1:0]   pur_q
);
    // R5
    pu_input_only_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    // R6
    bank_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pur_q[BANK_BIT] |-> (pad_oe[NPIN-1:PW] == '0 && pad_out[NPIN-1:PW] == '0));

    // R6
    bank_pu_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_pu != '0) |-> pur_q[BANK_BIT]);

    // R9
    rdmode_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_addr) == ADDR_RDMODE) |-> (bus_rdata[PW-1:1] == '0));

    // R2
    pur_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_addr) == ADDR_PUR && !$past(rst)) |-> (bus_rdata == $past(pur_q)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk i_chk (.*);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
    import gpio_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic [PW-1:0]   bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [PW-1:0]   bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (.*);

    // behavioural reference model
    logic [7:0]  md [5];
    logic [7:0]  mdir [5];
    logic [7:0]  m_pur;
    logic        m_pcr;
    logic [39:0] m_s1, m_s2;
    logic [7:0]  m_rd;

    function automatic logic [39:0] m_pu_req();
        logic [39:0] r = '0;
        for (int j = 0; j < 6; j++)
            if (m_pur[j]) r[8 + 4*j +: 4] = 4'hF;
        if (m_pur[6]) r[33:32] = 2'b11;
        return r;
    endfunction

    function automatic logic [39:0] m_oe();
        logic [39:0] r = '0;
        for (int k = 0; k < 5; k++)
            if (k == 0 || m_pur[7]) r[8*k +: 8] = mdir[k];
        return r;
    endfunction

    function automatic logic [39:0] m_out();
        logic [39:0] r = '0;
        for (int k = 0; k < 5; k++)
            if (k == 0 || m_pur[7]) r[8*k +: 8] = md[k];
        return r;
    endfunction

    function automatic logic [39:0] m_pu();
        return m_pur[7] ? (m_pu_req() & ~m_oe()) : 40'h0;
    endfunction

    function automatic logic [7:0] m_read(input logic [9:0] a);
        int off;
        if (a == 10'h3DF) return m_pur;
        if (a == 10'h3FF) return {7'h0, m_pcr};
        off = int'(a) - 'h3E0;
        if (off < 0 || off > 9) return 8'h00;
        if (off % 2 == 1) return mdir[off/2];
        if (off/2 >= 1 && !m_pur[7]) return 8'h00;
        if (off/2 == 0 && m_pcr) return md[0];
        return (mdir[off/2] & md[off/2]) | (~mdir[off/2] & m_s2[8*(off/2) +: 8]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 5; k++) begin md[k] = 0; mdir[k] = 0; end
            m_pur = 0; m_pcr = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
        end else begin
            m_rd = m_read(bus_addr);
            m_s2 = m_s1;
            m_s1 = pad_in;
            for (int k = 0; k < 5; k++) begin
                if (k >= 1 && !m_pur[7]) md[k] = 0;
                else if (bus_we) begin
                    if (int'(bus_addr) == 'h3E0 + 2*k) md[k] = bus_wdata;
                    if (int'(bus_addr) == 'h3E1 + 2*k) mdir[k] = bus_wdata;
                end
            end
            if (bus_we && bus_addr == 10'h3DF) m_pur = bus_wdata;
            if (bus_we && bus_addr == 10'h3FF) m_pcr = bus_wdata[0];
        end
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 pad_out model", pad_out, m_out());
            chk("R3 pad_oe model", pad_oe, m_oe());
            chk("R5 pad_pu model", pad_pu, m_pu());
            chk("R2 bus_rdata model", {32'h0, bus_rdata}, {32'h0, m_rd});
        end
    end

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act timeout exp completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_out", pad_out, 40'h0);
        chk("R1 pad_oe", pad_oe, 40'h0);
        chk("R1 pad_pu", pad_pu, 40'h0);
        chk("R1 rdata", {32'h0, bus_rdata}, 40'h0);
        rd(10'h3DF, v); chk("R1 pur", {32'h0, v}, 40'h0);

        // R2 map and write, R3 pins
        wr(10'h3E1, 8'hFF);
        wr(10'h3E0, 8'hA5);
        rd(10'h3E0, v); chk("R2 data0", {32'h0, v}, 40'hA5);
        rd(10'h3EA, v); chk("R2 unmapped", {32'h0, v}, 40'h0);
        wr(10'h3E1, 8'h0F);
        chk("R3 oe0", {32'h0, pad_oe[7:0]}, 40'h0F);
        chk("R3 out0", {32'h0, pad_out[7:0]}, 40'hA5);

        // R7 mixed read of port 0
        pad_in[7:0] = 8'h3C;
        repeat (3) @(negedge clk);
        rd(10'h3E0, v); chk("R7 pin read port0", {32'h0, v}, 40'h35);

        // R9, R8
        wr(10'h3FF, 8'hFF);
        rd(10'h3FF, v); chk("R9 rdmode upper", {32'h0, v}, 40'h01);
        rd(10'h3E0, v); chk("R8 latch read port0", {32'h0, v}, 40'hA5);

        // R6 bank disabled: writes dropped
        wr(10'h3E2, 8'h77);
        wr(10'h3E3, 8'hFF);
        rd(10'h3E2, v); chk("R6 data1 off", {32'h0, v}, 40'h0);
        rd(10'h3E3, v); chk("R6 dir1 off", {32'h0, v}, 40'h0);
        chk("R6 oe bank off", pad_oe[39:8], 40'h0);

        // enable bank
        wr(10'h3DF, 8'h80);
        wr(10'h3E3, 8'hFF);
        wr(10'h3E2, 8'h77);
        chk("R3 oe1", {32'h0, pad_oe[15:8]}, 40'hFF);
        chk("R3 out1", {32'h0, pad_out[15:8]}, 40'h77);

        // R4 grouping
        wr(10'h3DF, 8'hFF);
        chk("R4 pu groups", pad_pu, 40'h03_FF_FF_00_00);
        // R5 outputs lose pull-up
        wr(10'h3E5, 8'h0F);
        chk("R5 pu port2", {32'h0, pad_pu[23:16]}, 40'hF0);

        // R7 bank port ignores latch mode
        pad_in[23:16] = 8'hAA;
        wr(10'h3E4, 8'h55);
        repeat (2) @(negedge clk);
        rd(10'h3E4, v); chk("R7 pin read port2", {32'h0, v}, 40'hA5);

        // R6 disable: immediate quiet, clear, dir kept
        wr(10'h3DF, 8'h7F);
        chk("R6 out bank", pad_out[39:8], 40'h0);
        chk("R6 pu bank", pad_pu, 40'h0);
        rd(10'h3E2, v); chk("R6 data1 read", {32'h0, v}, 40'h0);
        rd(10'h3E3, v); chk("R6 dir1 kept", {32'h0, v}, 40'hFF);
        wr(10'h3DF, 8'h80);
        rd(10'h3E2, v); chk("R6 data1 cleared", {32'h0, v}, 40'h0);

        // R10 synchronizer depth
        wr(10'h3FF, 8'h00);
        wr(10'h3E1, 8'h00);
        pad_in[7:0] = 8'h00;
        @(negedge clk); bus_addr = 10'h3E0;
        repeat (3) @(negedge clk);
        pad_in[7:0] = 8'hC3;
        @(negedge clk); chk("R10 edge1", {32'h0, bus_rdata}, 40'h00);
        @(negedge clk); chk("R10 edge2", {32'h0, bus_rdata}, 40'h00);
        @(negedge clk); chk("R10 edge3", {32'h0, bus_rdata}, 40'hC3);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule